// File: doc/BRIEF.md
# Read Strobe Edge-Delay Sweep Engine

This engine finds the best read strobe placement for one byte lane of a memory interface. The strobe has a rising-edge delay and a falling-edge delay that are set independently. The engine tries every pair of the two delays. At each pair it asks an external memory-check agent to run a test and report pass or fail.

Each pair is tested in two stages. A quick single-word read comes first. A block read of roughly one kilobyte is requested only when the quick read passes. A pair counts as passing only when both stages pass. Over all passing pairs the engine records the smallest and largest delay on each axis. When the sweep ends it writes the midpoint of each axis into the strobe delay fields.

There are separate delay fields for the lower-nibble strobe and the upper-nibble strobe. In x8 mode the engine writes the same result into both sets of fields. In x4 mode it writes only the nibble selected at start. All fields reset to zero, which is a setting that lets basic reads work before tuning. If no pair passes, an error flag rises and every field is forced to zero.

Top module: `strobe_eye_sweep`

## Requirements
- R1: After reset `test_req`, `busy`, `done` and `no_eye` are 0, and all four delay fields (`rise_lo`, `fall_lo`, `rise_hi`, `fall_hi`) are 0.
- R2: A `start` pulse in idle begins a sweep of two's-complement delays from -16 to +15. The rising delay is the outer loop and the falling delay is the inner loop, both ascending, so exactly 1024 word tests are issued in that order.
- R3: For each pair a word test (`test_block`=0) is issued first. A block test (`test_block`=1) for the same pair follows only when the word test reported pass. The pair counts as passing only if the block test also passes.
- R4: `test_req` stays high until `test_ack` is seen. While it is pending, `test_block`, `rise_try` and `fall_try` hold steady. `test_pass` is sampled in the cycle `test_ack` is high.
- R5: The result on each axis is (min+max)>>>1 over all passing pairs, computed with one extra bit and an arithmetic shift, so it rounds toward minus infinity.
- R6: With `x8_mode`=1 at start, both the lower and upper fields receive the result: `rise_lo`=`rise_hi`=rising centre, and `fall_lo`=`fall_hi`=falling centre.
- R7: With `x8_mode`=0, only the nibble named by `nib_sel` at start is written (0 = lower fields, 1 = upper fields). The other nibble's fields keep their previous values.
- R8: If no pair passes, `no_eye` rises at the end of the sweep and all four fields become 0. `no_eye` stays high until the next start.
- R9: A `start` pulse during a sweep has no effect. The sweep order and the result are unchanged.
- R10: `done` is a one-cycle pulse in the cycle the fields take their new values, and `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (ignored while busy) |
| x8_mode | input | 1 | 1: one strobe per byte, write both nibbles; 0: x4 |
| nib_sel | input | 1 | x4 target nibble: 0 lower, 1 upper |
| test_req | output | 1 | Test request to the check agent |
| test_block | output | 1 | Test size: 0 single word, 1 about 1 KB block |
| rise_try | output | 5 | Rising-edge delay under test (signed) |
| fall_try | output | 5 | Falling-edge delay under test (signed) |
| test_ack | input | 1 | Agent response valid |
| test_pass | input | 1 | Agent verdict, valid with test_ack |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when results are written |
| no_eye | output | 1 | No passing pair was found |
| rise_lo | output | 5 | Lower-nibble rising delay field |
| fall_lo | output | 5 | Lower-nibble falling delay field |
| rise_hi | output | 5 | Upper-nibble rising delay field |
| fall_hi | output | 5 | Upper-nibble falling delay field |

## Verification
Some rules are checked on every cycle:
- a pending request holds its size and delays;
- a block test is entered only straight after a passing word test;
- `done` lasts a single cycle;
- a stray start does not end a sweep;
- x8 results match across nibbles;
- a missing eye leaves zeros.

Other behaviour can only be shown by the bench scenarios. These scenarios use passing windows of known shape, including a window that passes word tests but fails block tests, a single-point eye, negative midpoints that need the floor rounding, and x4 runs that must leave the other nibble alone. Those scenarios also cover the full 1024-point ordering, the count of block tests, and the retained field values.

// File: rtl/strobe_eye_sweep.sv
module strobe_eye_sweep #(
  parameter int DW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 x8_mode,
  input  logic                 nib_sel,
  output logic                 test_req,
  output logic                 test_block,
  output logic signed [DW-1:0] rise_try,
  output logic signed [DW-1:0] fall_try,
  input  logic                 test_ack,
  input  logic                 test_pass,
  output logic                 busy,
  output logic                 done,
  output logic                 no_eye,
  output logic signed [DW-1:0] rise_lo,
  output logic signed [DW-1:0] fall_lo,
  output logic signed [DW-1:0] rise_hi,
  output logic signed [DW-1:0] fall_hi
);

  localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] DZERO = '0;

  typedef enum logic [2:0] {S_IDLE, S_WORD, S_BLOCK, S_STEP, S_FIN} state_t;

  state_t state;
  logic found, m_x8, m_nib;
  logic signed [DW-1:0] r_min, r_max, f_min, f_max;

  assign test_req   = (state == S_WORD) || (state == S_BLOCK);
  assign test_block = (state == S_BLOCK);
  assign busy       = (state != S_IDLE);

  logic signed [DW:0] r_sum, f_sum, r_mid, f_mid;
  assign r_sum = {r_min[DW-1], r_min} + {r_max[DW-1], r_max};
  assign f_sum = {f_min[DW-1], f_min} + {f_max[DW-1], f_max};
  assign r_mid = r_sum >>> 1;
  assign f_mid = f_sum >>> 1;

  logic take_point;
  assign take_point = (state == S_BLOCK) && test_ack && test_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rise_try <= DZERO;
      fall_try <= DZERO;
      found    <= 1'b0;
      m_x8     <= 1'b0;
      m_nib    <= 1'b0;
      r_min    <= DZERO;
      r_max    <= DZERO;
      f_min    <= DZERO;
      f_max    <= DZERO;
      done     <= 1'b0;
      no_eye   <= 1'b0;
      rise_lo  <= DZERO;
      fall_lo  <= DZERO;
      rise_hi  <= DZERO;
      fall_hi  <= DZERO;
    end else begin
      done <= 1'b0;
      if (take_point) begin
        found <= 1'b1;
        if (!found || rise_try < r_min) r_min <= rise_try;
        if (!found || rise_try > r_max) r_max <= rise_try;
        if (!found || fall_try < f_min) f_min <= fall_try;
        if (!found || fall_try > f_max) f_max <= fall_try;
      end
      case (state)
        S_IDLE: if (start) begin
          rise_try <= DMIN;
          fall_try <= DMIN;
          found    <= 1'b0;
          no_eye   <= 1'b0;
          m_x8     <= x8_mode;
          m_nib    <= nib_sel;
          state    <= S_WORD;
        end
        S_WORD: if (test_ack) state <= test_pass ? S_BLOCK : S_STEP;
        S_BLOCK: if (test_ack) state <= S_STEP;
        S_STEP: begin
          if (fall_try == DMAX) begin
            fall_try <= DMIN;
            if (rise_try == DMAX) state <= S_FIN;
            else begin
              rise_try <= rise_try + 1'b1;
              state    <= S_WORD;
            end
          end else begin
            fall_try <= fall_try + 1'b1;
            state    <= S_WORD;
          end
        end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (!found) begin
            no_eye  <= 1'b1;
            rise_lo <= DZERO;
            fall_lo <= DZERO;
            rise_hi <= DZERO;
            fall_hi <= DZERO;
          end else begin
            if (m_x8 || !m_nib) begin
              rise_lo <= r_mid[DW-1:0];
              fall_lo <= f_mid[DW-1:0];
            end
            if (m_x8 || m_nib) begin
              rise_hi <= r_mid[DW-1:0];
              fall_hi <= f_mid[DW-1:0];
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_ack) |=> (test_req && $stable(test_block) && $stable(rise_try) && $stable(fall_try)));

  // R3
  a_r3_block_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (test_block && !$past(test_block)) |-> $past(test_req && !test_block && test_ack && test_pass));

  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_FIN) |=> busy);

  // R6
  a_r6_x8_match: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_x8) |-> (rise_lo == rise_hi && fall_lo == fall_hi));

  // R8
  a_r8_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    no_eye |-> (rise_lo == DZERO && fall_lo == DZERO && rise_hi == DZERO && fall_hi == DZERO));

endmodule

// File: tb/strobe_eye_sweep_test.sv
module strobe_eye_sweep_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, x8_mode = 1'b0, nib_sel = 1'b0;
  logic test_ack = 1'b0, test_pass = 1'b0;
  logic test_req, test_block, busy, done, no_eye;
  logic signed [4:0] rise_try, fall_try, rise_lo, fall_lo, rise_hi, fall_hi;

  always #2.5 clk = ~clk;

  strobe_eye_sweep #(.DW(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x8_mode(x8_mode), .nib_sel(nib_sel),
    .test_req(test_req), .test_block(test_block), .rise_try(rise_try), .fall_try(fall_try),
    .test_ack(test_ack), .test_pass(test_pass), .busy(busy), .done(done), .no_eye(no_eye),
    .rise_lo(rise_lo), .fall_lo(fall_lo), .rise_hi(rise_hi), .fall_hi(fall_hi));

  // x8, nib, latency, word r lo/hi, f lo/hi, block r lo/hi, f lo/hi, exp r, exp f, exp no_eye
  localparam int NV = 6;
  localparam int VEC [NV][14] = '{
    '{1, 0, 0,  -6,  8,  -5,  7,  -4,  6,  -3,  5,   1,   1, 0},
    '{0, 0, 1, -16, 15, -16, 15, -16, -9,  10, 15, -13,  12, 0},
    '{0, 1, 2,   3, 15, -16, -2,   3, 15, -16, -2,   9,  -9, 0},
    '{1, 0, 0,  -8, -6,  10, 12,  -7, -7,  11, 11,  -7,  11, 0},
    '{1, 1, 1,  -2,  2,  -2,  2,   1,  0,   1,  0,   0,   0, 1},
    '{1, 0, 0,  -1,  1,  -1,  1,  -1,  0,  -1, -1,  -1,  -1, 0}
  };

  int checks = 0, fails = 0;
  int cv = 0;
  int lat_cnt = 0, idx = 0, blocks = 0, word_pass = 0;
  int order_err = 0, block_err = 0, hold_err = 0;
  logic seen = 1'b0, last_word_ok = 1'b0;
  int held_r, held_f, held_b, last_r, last_f;
  int er_lo = 0, ef_lo = 0, er_hi = 0, ef_hi = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit in_rect(input int r, input int f, input int rl, input int rh,
                                 input int fl, input int fh);
    return (r >= rl) && (r <= rh) && (f >= fl) && (f <= fh);
  endfunction

  always @(negedge clk) begin
    if (test_req && !test_ack) begin
      if (!seen) begin
        seen = 1'b1;
        held_r = int'(rise_try); held_f = int'(fall_try); held_b = int'(test_block);
      end else if (held_r != int'(rise_try) || held_f != int'(fall_try) || held_b != int'(test_block))
        hold_err++;
      if (lat_cnt >= VEC[cv][2]) begin
        lat_cnt = 0;
        seen = 1'b0;
        test_ack = 1'b1;
        if (!test_block) begin
          test_pass = in_rect(int'(rise_try), int'(fall_try), VEC[cv][3], VEC[cv][4], VEC[cv][5], VEC[cv][6]);
          if (int'(rise_try) != -16 + idx / 32 || int'(fall_try) != -16 + idx % 32) order_err++;
          idx++;
          last_word_ok = test_pass;
          last_r = int'(rise_try); last_f = int'(fall_try);
        end else begin
          test_pass = in_rect(int'(rise_try), int'(fall_try), VEC[cv][7], VEC[cv][8], VEC[cv][9], VEC[cv][10]);
          if (!last_word_ok || last_r != int'(rise_try) || last_f != int'(fall_try)) block_err++;
          blocks++;
        end
      end else lat_cnt++;
    end else begin
      test_ack = 1'b0;
      test_pass = 1'b0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!test_req && !busy && !done && !no_eye, "R1 control outputs idle", int'(busy), 0);
    chk(rise_lo == 0 && fall_lo == 0 && rise_hi == 0 && fall_hi == 0, "R1 fields zero", int'(rise_lo), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!test_req && !busy, "R1 no request without start", int'(test_req), 0);

    for (int v = 0; v < NV; v++) begin
      cv = v;
      idx = 0; blocks = 0; order_err = 0; block_err = 0; hold_err = 0; lat_cnt = 0;
      word_pass = 0;
      for (int r = -16; r < 16; r++)
        for (int f = -16; f < 16; f++)
          if (in_rect(r, f, VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6])) word_pass++;
      x8_mode = VEC[v][0][0];
      nib_sel = VEC[v][1][0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      x8_mode = ~x8_mode;
      nib_sel = ~nib_sel;
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);

      if (VEC[v][13] != 0) begin
        er_lo = 0; ef_lo = 0; er_hi = 0; ef_hi = 0;
      end else begin
        if (VEC[v][0] != 0 || VEC[v][1] == 0) begin er_lo = VEC[v][11]; ef_lo = VEC[v][12]; end
        if (VEC[v][0] != 0 || VEC[v][1] != 0) begin er_hi = VEC[v][11]; ef_hi = VEC[v][12]; end
      end
      chk(idx == 1024, "R2 word test count", idx, 1024);
      chk(order_err == 0, "R2 sweep order (R9 start ignored)", order_err, 0);
      chk(block_err == 0, "R3 block only after passing word", block_err, 0);
      chk(blocks == word_pass, "R3 block test count", blocks, word_pass);
      chk(hold_err == 0, "R4 request held stable", hold_err, 0);
      chk(int'(no_eye) == VEC[v][13], "R8 no_eye flag", int'(no_eye), VEC[v][13]);
      chk(int'(rise_lo) == er_lo, "R5/R6/R7 rise_lo", int'(rise_lo), er_lo);
      chk(int'(fall_lo) == ef_lo, "R5/R6/R7 fall_lo", int'(fall_lo), ef_lo);
      chk(int'(rise_hi) == er_hi, "R5/R6/R7 rise_hi", int'(rise_hi), er_hi);
      chk(int'(fall_hi) == ef_hi, "R5/R6/R7 fall_hi", int'(fall_hi), ef_hi);
      chk(!busy, "R10 busy low at done", int'(busy), 0);
      @(negedge clk);
      chk(!done, "R10 done single cycle", int'(done), 0);
      chk(int'(no_eye) == VEC[v][13], "R8 no_eye held", int'(no_eye), VEC[v][13]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule